// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block is the digital controller placed in front of a successive-approximation converter. A trigger pulse starts one pass through the channels whose enable bit is set, from the lowest index up. For each channel the block may first wait for the analog front end to settle. It then tracks the input for a programmable time, pulses a conversion start, and waits for the analog cell to report done. The result goes into a 16-bit last-converted-data word. A one-cycle DMA request is raised for every word stored.

Each channel carries its own gain code, offset bit and differential bit. When the analog-change option is on and the channel about to be converted differs in any of these from the channel converted last, a settling wait is inserted before tracking. A reset forgets the last converted settings, so the first conversion after reset always settles while the option is on. When the tag option is on, the upper four bits of each word carry the channel index.

The result leaves as a strobe, not as a valid/ready stream. The word register is written once per conversion, and `dma_req_o` marks the single cycle in which a new word first appears. There is no back-pressure: the consumer must take each word before the next conversion completes, and the word stays unchanged until then.

Top module: `adc_seq_top`

## Requirements
- R1: One pass converts every channel whose bit in `ch_en_i` is set, once each, in ascending index order. A trigger with no channel enabled causes no conversion.
- R2: A trigger that arrives while a pass is running is ignored. The pass completes with exactly the words of its own channels.
- R3: Tracking lasts `track_cfg_i`+1 cycles. With no settling wait, `conv_start_o` rises `track_cfg_i`+2 cycles after the clock edge that samples the trigger.
- R4: With `anach_en_i` high, a channel whose {gain, offset, differential} settings differ from those of the channel converted last gets a settling wait of `settle_cfg_i`+1 cycles before tracking. Any single field that differs is enough.
- R5: With `anach_en_i` low, no settling wait is inserted, whatever the settings are.
- R6: Reset clears the record of the last converted settings. With `anach_en_i` high, the first conversion after reset therefore always settles.
- R7: `data_o` bits 11:0 hold the 12-bit result. Bits 15:12 hold the channel index when `tag_en_i` is high, and zero when it is low.
- R8: `dma_req_o` pulses for exactly one cycle, in the cycle after `conv_done_i` is sampled, and `data_o` then holds the new word until the next request.
- R9: `conv_start_o` is a one-cycle pulse, and `conv_ch_o` stays stable from the start pulse until the result is captured.
- R10: Repeated triggers with unchanged configuration produce the same ordered channel structure each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Sequence trigger, sampled while idle |
| ch_en_i | input | NCH | Channel enable mask |
| gain_i | input | NCH*GAIN_W | Per-channel gain codes, channel i in bits [i*GAIN_W +: GAIN_W] |
| offs_i | input | NCH | Per-channel offset bit |
| diff_i | input | NCH | Per-channel differential-mode bit |
| anach_en_i | input | 1 | Insert settling wait when settings change |
| tag_en_i | input | 1 | Put the channel index into bits 15:12 |
| settle_cfg_i | input | CNT_W | Settling count N, giving N+1 cycles |
| track_cfg_i | input | CNT_W | Tracking count N, giving N+1 cycles |
| conv_start_o | output | 1 | Start-of-conversion pulse to the analog cell |
| conv_ch_o | output | CH_W | Channel being converted |
| conv_done_i | input | 1 | Conversion complete from the analog cell |
| conv_data_i | input | RES_W | Conversion result, valid with `conv_done_i` |
| data_o | output | WORD_W | Last-converted-data word |
| dma_req_o | output | 1 | One-cycle DMA request per stored word |

## Verification
The bench measures the cycle of every conversion start against the trigger edge and against the previous start. A settling wait that is missing, extra, or one cycle off shows up as a wrong latency or gap. Separate runs change only the gain, only the offset, or only the differential bit, so a comparator that ignores a field would skip a wait it owes. A second trigger fired mid-pass would, in a design that accepted it, show up as extra words. The first conversion after a fresh reset must settle even though every setting is zero, so a record that is not cleared would be caught. Tag bits are checked both on and off, and an empty mask must yield no word.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEL    = 3'd1,
    ST_SETTLE = 3'd2,
    ST_TRACK  = 3'd3,
    ST_START  = 3'd4,
    ST_WAIT   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/adcs_pick.sv
// Lowest-index set bit of a pending mask.
module adcs_pick #(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  mask,
  output logic [CH_W-1:0] idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = CH_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcs_timer.sv
// Loadable down-counter; a loaded value N expires after N+1 cycles.
module adcs_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/adcs_cfgcmp.sv
// Holds the analog settings of the last converted channel and flags a change.
module adcs_cfgcmp #(
  parameter int NCH    = 8,
  parameter int GAIN_W = 2,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*GAIN_W-1:0] gain_i,
  input  logic [NCH-1:0]        offs_i,
  input  logic [NCH-1:0]        diff_i,
  input  logic [CH_W-1:0]       cmp_idx,
  input  logic [CH_W-1:0]       rec_idx,
  input  logic                  rec_we,
  output logic                  changed
);
  localparam int SET_W = GAIN_W + 2;

  logic [SET_W-1:0] rec_q;
  logic             rec_vld_q;
  logic [SET_W-1:0] cmp_set, new_set;

  function automatic logic [SET_W-1:0] settings_of(
    input logic [CH_W-1:0]       ch,
    input logic [NCH*GAIN_W-1:0] g,
    input logic [NCH-1:0]        o,
    input logic [NCH-1:0]        d
  );
    return {g[int'(ch)*GAIN_W +: GAIN_W], o[ch], d[ch]};
  endfunction

  assign cmp_set = settings_of(cmp_idx, gain_i, offs_i, diff_i);
  assign new_set = settings_of(rec_idx, gain_i, offs_i, diff_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q     <= '0;
      rec_vld_q <= 1'b0;
    end else if (rec_we) begin
      rec_q     <= new_set;
      rec_vld_q <= 1'b1;
    end
  end

  assign changed = !rec_vld_q || (cmp_set != rec_q);
endmodule

// File: rtl/adcs_fmt.sv
// Last-converted-data word and its DMA request strobe.
module adcs_fmt #(
  parameter int RES_W  = 12,
  parameter int WORD_W = 16,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              tag_en,
  input  logic [CH_W-1:0]   ch,
  input  logic [RES_W-1:0]  res,
  output logic [WORD_W-1:0] word_o,
  output logic              req_o
);
  localparam int TAG_W = WORD_W - RES_W;

  logic [TAG_W-1:0] tag;
  assign tag = tag_en ? TAG_W'(ch) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      req_o  <= 1'b0;
    end else begin
      req_o <= we;
      if (we) word_o <= {tag, res};
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int NCH    = 8,
  parameter int GAIN_W = 2,
  parameter int CNT_W  = 4,
  parameter int RES_W  = 12,
  parameter int WORD_W = 16,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_i,
  input  logic [NCH-1:0]        ch_en_i,
  input  logic [NCH*GAIN_W-1:0] gain_i,
  input  logic [NCH-1:0]        offs_i,
  input  logic [NCH-1:0]        diff_i,
  input  logic                  anach_en_i,
  input  logic                  tag_en_i,
  input  logic [CNT_W-1:0]      settle_cfg_i,
  input  logic [CNT_W-1:0]      track_cfg_i,
  output logic                  conv_start_o,
  output logic [CH_W-1:0]       conv_ch_o,
  input  logic                  conv_done_i,
  input  logic [RES_W-1:0]      conv_data_i,
  output logic [WORD_W-1:0]     data_o,
  output logic                  dma_req_o
);
  import adcs_pkg::*;

  seq_state_t       st_q;
  logic [NCH-1:0]   pend_q;
  logic [CH_W-1:0]  cur_q;
  logic [CH_W-1:0]  nx_idx;
  logic             nx_any;
  logic             changed;
  logic             t_load, t_dec, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             cap_we;

  adcs_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .mask(pend_q), .idx(nx_idx), .any(nx_any)
  );

  adcs_cfgcmp #(.NCH(NCH), .GAIN_W(GAIN_W), .CH_W(CH_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .gain_i(gain_i), .offs_i(offs_i), .diff_i(diff_i),
    .cmp_idx(nx_idx), .rec_idx(cur_q),
    .rec_we(st_q == ST_START), .changed(changed)
  );

  adcs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(t_load), .load_val(t_val), .dec(t_dec), .zero(t_zero)
  );

  adcs_fmt #(.RES_W(RES_W), .WORD_W(WORD_W), .CH_W(CH_W)) u_fmt (
    .clk(clk), .rst_n(rst_n),
    .we(cap_we), .tag_en(tag_en_i), .ch(cur_q), .res(conv_data_i),
    .word_o(data_o), .req_o(dma_req_o)
  );

  logic settle_now;
  assign settle_now = anach_en_i && changed;

  // Timer control
  always_comb begin
    t_load = 1'b0;
    t_dec  = 1'b0;
    t_val  = track_cfg_i;
    unique case (st_q)
      ST_SEL: begin
        t_load = nx_any;
        t_val  = settle_now ? settle_cfg_i : track_cfg_i;
      end
      ST_SETTLE: begin
        if (t_zero) t_load = 1'b1;
        else        t_dec  = 1'b1;
      end
      ST_TRACK: t_dec = !t_zero;
      default: ;
    endcase
  end

  assign cap_we = (st_q == ST_WAIT) && conv_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:
          if (trig_i && (ch_en_i != '0)) begin
            pend_q <= ch_en_i;
            st_q   <= ST_SEL;
          end
        ST_SEL:
          if (!nx_any) st_q <= ST_IDLE;
          else begin
            cur_q          <= nx_idx;
            pend_q[nx_idx] <= 1'b0;
            st_q           <= settle_now ? ST_SETTLE : ST_TRACK;
          end
        ST_SETTLE: if (t_zero) st_q <= ST_TRACK;
        ST_TRACK:  if (t_zero) st_q <= ST_START;
        ST_START:  st_q <= ST_WAIT;
        ST_WAIT:
          if (conv_done_i) st_q <= (pend_q == '0) ? ST_IDLE : ST_SEL;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_start_o = (st_q == ST_START);
  assign conv_ch_o    = cur_q;
endmodule

// File: rtl/adcs_chk.sv
module adcs_chk #(
  parameter int RES_W  = 12,
  parameter int WORD_W = 16,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tag_en_i,
  input logic              conv_start_o,
  input logic [CH_W-1:0]   conv_ch_o,
  input logic              conv_done_i,
  input logic [RES_W-1:0]  conv_data_i,
  input logic [WORD_W-1:0] data_o,
  input logic              dma_req_o
);
  a_r8_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |=> !dma_req_o);

  a_r8_dma_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> $past(conv_done_i));

  a_r7_result_bits: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> data_o[RES_W-1:0] == $past(conv_data_i));

  a_r7_tag_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_o && !$past(tag_en_i)) |-> data_o[WORD_W-1:RES_W] == '0);

  a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req_o |=> (dma_req_o || $stable(data_o)));

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  a_r9_ch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> $stable(conv_ch_o));
endmodule

bind adc_seq_top adcs_chk #(.RES_W(RES_W), .WORD_W(WORD_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_en_i(tag_en_i),
  .conv_start_o(conv_start_o), .conv_ch_o(conv_ch_o),
  .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
  .data_o(data_o), .dma_req_o(dma_req_o)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
  localparam int NCH = 8, GAIN_W = 2, CNT_W = 4, RES_W = 12, WORD_W = 16, CH_W = 3;
  localparam int S = 3, T = 2;

  logic clk = 0, rst_n = 0, trig = 0;
  logic [NCH-1:0] ch_en = '0, offs = '0, diff = '0;
  logic [NCH*GAIN_W-1:0] gain = '0;
  logic anach = 0, tag = 0;
  logic conv_done = 0;
  logic [RES_W-1:0] conv_data = '0;
  logic conv_start, dma_req;
  logic [CH_W-1:0] conv_ch;
  logic [WORD_W-1:0] data;

  int errors = 0, checks = 0, cyc = 0, trig_cyc = 0;
  int st_cyc[$];
  int st_ch[$];
  int words[$];
  int viol = 0;
  logic prev_req = 0, prev_start = 0;
  logic [WORD_W-1:0] prev_data = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_top #(.NCH(NCH), .GAIN_W(GAIN_W), .CNT_W(CNT_W), .RES_W(RES_W),
                .WORD_W(WORD_W), .CH_W(CH_W)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ch_en_i(ch_en), .gain_i(gain),
    .offs_i(offs), .diff_i(diff), .anach_en_i(anach), .tag_en_i(tag),
    .settle_cfg_i(CNT_W'(S)), .track_cfg_i(CNT_W'(T)),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .data_o(data), .dma_req_o(dma_req)
  );

  // Analog cell model: done one cycle after the start pulse is seen.
  always begin
    @(negedge clk);
    if (conv_start) begin
      @(negedge clk);
      conv_done = 1;
      conv_data = 12'hC30 + RES_W'(conv_ch);
      @(negedge clk);
      conv_done = 0;
    end
  end

  // Monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (conv_start) begin st_cyc.push_back(cyc); st_ch.push_back(int'(conv_ch)); end
    if (dma_req) words.push_back(int'(data));
    if (dma_req && prev_req) viol++;
    if (conv_start && prev_start) viol++;
    if (!dma_req && rst_n && prev_data != data) viol++;
    prev_req = dma_req; prev_start = conv_start; prev_data = data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic clear();
    st_cyc.delete(); st_ch.delete(); words.delete();
  endtask

  task automatic fire();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0; trig_cyc = cyc;
  endtask

  task automatic run(input logic [NCH-1:0] m);
    clear();
    ch_en = m;
    fire();
    repeat (150) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(conv_start == 0 && dma_req == 0 && data == '0, "R8 reset outputs",
        int'({conv_start, dma_req}) + int'(data), 0);
  endtask

  task automatic t_first_settle();
    anach = 1; tag = 0; gain = '0; offs = '0; diff = '0;
    run(8'h01);
    chk(st_cyc.size() == 1 && st_cyc[0] - trig_cyc == S + T + 3, "R6 first after reset settles",
        st_cyc.size() ? st_cyc[0] - trig_cyc : -1, S + T + 3);
    run(8'h01);
    chk(st_cyc.size() == 1 && st_cyc[0] - trig_cyc == T + 2, "R3 tracking latency",
        st_cyc.size() ? st_cyc[0] - trig_cyc : -1, T + 2);
  endtask

  task automatic t_order();
    int exp_ch[4] = '{0, 2, 5, 7};
    anach = 0; tag = 0;
    for (int rep = 0; rep < 2; rep++) begin
      run(8'hA5);
      chk(words.size() == 4 && st_ch.size() == 4, "R1 word count", words.size(), 4);
      if (words.size() == 4 && st_ch.size() == 4)
        for (int i = 0; i < 4; i++) begin
          chk(st_ch[i] == exp_ch[i], rep ? "R10 repeated order" : "R1 ascending order",
              st_ch[i], exp_ch[i]);
          chk(words[i] == 'hC30 + exp_ch[i], "R7 untagged word", words[i], 'hC30 + exp_ch[i]);
        end
    end
  endtask

  task automatic t_tag();
    tag = 1;
    run(8'h81);
    chk(words.size() == 2, "R7 tagged count", words.size(), 2);
    if (words.size() == 2) begin
      chk(words[0] == 'h0C30, "R7 tag ch0", words[0], 'h0C30);
      chk(words[1] == 'h7C37, "R7 tag ch7", words[1], 'h7C37);
    end
    tag = 0;
  endtask

  task automatic t_settle(input bit en);
    // ch1 matches last record (all zero); ch2 gain differs; ch3 only diff differs from ch2;
    // ch4 only offset differs from ch3.
    gain = '0; offs = '0; diff = '0;
    gain[2*GAIN_W +: GAIN_W] = 2'd1;
    gain[3*GAIN_W +: GAIN_W] = 2'd1; diff[3] = 1;
    gain[4*GAIN_W +: GAIN_W] = 2'd1; diff[4] = 1; offs[4] = 1;
    anach = en;
    run(8'h1E);
    chk(st_cyc.size() == 4, en ? "R4 count" : "R5 count", st_cyc.size(), 4);
    if (st_cyc.size() == 4) begin
      chk(st_cyc[0] - trig_cyc == T + 2, en ? "R4 equal settings no wait" : "R5 first",
          st_cyc[0] - trig_cyc, T + 2);
      for (int i = 1; i < 4; i++)
        chk(st_cyc[i] - st_cyc[i-1] == (en ? S + T + 5 : T + 4),
            en ? "R4 settle on change" : "R5 no settle when disabled",
            st_cyc[i] - st_cyc[i-1], en ? S + T + 5 : T + 4);
    end
  endtask

  task automatic t_busy();
    anach = 0;
    clear();
    ch_en = 8'h06;
    fire();
    repeat (4) @(negedge clk);
    fire();
    repeat (150) @(negedge clk);
    chk(words.size() == 2, "R2 trigger while busy ignored", words.size(), 2);
  endtask

  task automatic t_empty();
    run(8'h00);
    chk(words.size() == 0 && st_cyc.size() == 0, "R1 empty mask", words.size(), 0);
  endtask

  task automatic t_pulses();
    chk(viol == 0, "R8 R9 one-cycle pulses and held word", viol, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_first_settle();
    t_order();
    t_tag();
    t_settle(1'b1);
    t_settle(1'b0);
    t_busy();
    t_empty();
    t_pulses();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule